// File: doc/BRIEF.md
# Pack, Scaled-Add and Compare Unit

This unit is one execution lane of a 64-bit integer datapath. Given two operands, a 6-bit immediate shift amount and a 5-bit operation code, it produces one 64-bit result. The operations fall into three families:

- **Packing:** gathers halves, quarters or bytes of the operands into a new word. The word forms sign-extend their 32-bit result.
- **Scaled-index addition:** adds a shifted copy of the first operand to the second. Some variants first zero-extend the low 32 bits of the first operand, and one variant is a shift-only form.
- **Compare and widen:** signed and unsigned minimum and maximum, plus byte and halfword sign extension.

The result path is purely combinational. Behind it sits an optional output register with a valid flag, so the surrounding pipeline and the test bench can check results cycle by cycle. Instruction decoding and overflow reporting belong to the surrounding core.

Top module: `pkscl_unit`

## Requirements
- R1: Code 0 gives {B[31:0], A[31:0]}. Code 1 gives {B[63:32], A[63:32]}.
- R2: Code 2 gives B[7:0] in bits 15:8 and A[7:0] in bits 7:0, with bits 63:16 zero.
- R3: Code 3 gives A[15:0] in bits 15:0 and B[15:0] sign-extended into bits 63:16. Code 4 builds the 32-bit word {B[31:16], A[31:16]} and sign-extends it to 64 bits.
- R4: Codes 5, 6 and 7 give (A << N) + B for N = 1, 2 and 3. The sum wraps modulo 2^64.
- R5: Codes 8, 9, 10 and 11 zero-extend A[31:0], shift it left by N = 0, 1, 2 and 3, and add the full 64-bit B, modulo 2^64.
- R6: Code 12 uses the 6-bit shift amount S. For S below 32 it places zero-extended A[31:0] starting at bit S. For S of 32 or more it shifts all of A left by S. Bits moved past bit 63 are dropped.
- R7: Codes 13 and 14 give the signed two's-complement minimum and maximum of A and B.
- R8: Codes 15 and 16 give the unsigned minimum and maximum of A and B.
- R9: Code 17 sign-extends A[7:0] to 64 bits. Code 18 sign-extends A[15:0] to 64 bits.
- R10: Codes 19 to 31 give a zero result.
- R11: One clock after a cycle with in_valid high, out_valid is high and out_result holds that cycle's result. After a cycle with in_valid low, out_valid is low and out_result keeps its previous value.
- R12: While rst_n is low, out_valid and out_result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and code are meaningful this cycle |
| op | input | 5 | Operation code |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| shamt | input | 6 | Immediate shift amount for code 12 |
| result | output | 64 | Combinational result |
| out_valid | output | 1 | Registered valid flag |
| out_result | output | 64 | Registered result |

## Verification
The assertions assume that, in any cycle where in_valid is high, op, a, b and shamt are stable from one clock edge until the next. They also assume those inputs carry no unknown bits while in_valid is high; in cycles without in_valid, the inputs may hold anything. The bench respects both assumptions by changing inputs only on the falling edge and holding them through the following rising edge. The one exception is a deliberate idle cycle, where in_valid is low and the inputs are scrambled to show that the register holds its value.

// File: rtl/pkscl_pkg.sv
package pkscl_pkg;

  localparam int DW = 64;

  typedef enum logic [4:0] {
    OP_PACK_LO     = 5'd0,
    OP_PACK_HI     = 5'd1,
    OP_PACK_BYTE   = 5'd2,
    OP_PACK_QSX    = 5'd3,
    OP_PACK_HQSX   = 5'd4,
    OP_SCADD1      = 5'd5,
    OP_SCADD2      = 5'd6,
    OP_SCADD3      = 5'd7,
    OP_ZADD0       = 5'd8,
    OP_ZADD1       = 5'd9,
    OP_ZADD2       = 5'd10,
    OP_ZADD3       = 5'd11,
    OP_ZSHL        = 5'd12,
    OP_SMIN        = 5'd13,
    OP_SMAX        = 5'd14,
    OP_UMIN        = 5'd15,
    OP_UMAX        = 5'd16,
    OP_SX8         = 5'd17,
    OP_SX16        = 5'd18
  } op_e;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_PACK = 2'd1,
    GRP_ADD  = 2'd2,
    GRP_CMP  = 2'd3
  } grp_e;

  // Family that owns an operation code
  function automatic grp_e op_group(input logic [4:0] code);
    if (code <= 5'd4)       return GRP_PACK;
    else if (code <= 5'd12) return GRP_ADD;
    else if (code <= 5'd18) return GRP_CMP;
    else                    return GRP_NONE;
  endfunction

  // Left-scale amount for the scaled-add codes
  function automatic logic [1:0] add_scale(input logic [4:0] code);
    case (code)
      5'd5, 5'd9:  return 2'd1;
      5'd6, 5'd10: return 2'd2;
      5'd7, 5'd11: return 2'd3;
      default:     return 2'd0;
    endcase
  endfunction

  // Whether a scaled-add code first zero-extends the low word of A
  function automatic logic add_zext(input logic [4:0] code);
    return (code >= 5'd8) && (code <= 5'd11);
  endfunction

endpackage

// File: rtl/pkscl_pack.sv
module pkscl_pack #(
  parameter int W = pkscl_pkg::DW
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  import pkscl_pkg::*;

  localparam int HALF = W / 2;
  localparam int QTR  = W / 4;
  localparam int BYTE = 8;

  logic [W-1:0]    lo_pair;
  logic [W-1:0]    hi_pair;
  logic [W-1:0]    byte_pair;
  logic [W-1:0]    qtr_sx;
  logic [HALF-1:0] hq_word;
  logic [W-1:0]    hq_sx;

  always_comb begin
    lo_pair   = {b[HALF-1:0], a[HALF-1:0]};
    hi_pair   = {b[W-1:HALF], a[W-1:HALF]};
    byte_pair = {{(W-2*BYTE){1'b0}}, b[BYTE-1:0], a[BYTE-1:0]};
    qtr_sx    = {{(W-2*QTR){b[QTR-1]}}, b[QTR-1:0], a[QTR-1:0]};
    hq_word   = {b[HALF-1:QTR], a[HALF-1:QTR]};
    hq_sx     = {{HALF{hq_word[HALF-1]}}, hq_word};
  end

  always_comb begin
    case (op)
      OP_PACK_LO:   res = lo_pair;
      OP_PACK_HI:   res = hi_pair;
      OP_PACK_BYTE: res = byte_pair;
      OP_PACK_QSX:  res = qtr_sx;
      OP_PACK_HQSX: res = hq_sx;
      default:      res = '0;
    endcase
  end

endmodule

// File: rtl/pkscl_scadd.sv
module pkscl_scadd #(
  parameter int W = pkscl_pkg::DW
) (
  input  logic [4:0]          op,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic [$clog2(W)-1:0] shamt,
  output logic [W-1:0]        res
);
  import pkscl_pkg::*;

  localparam int HALF   = W / 2;
  localparam int SHW    = $clog2(W);
  localparam int LANES  = 4;

  logic [W-1:0] a_zext;
  logic [W-1:0] full_sum [LANES];
  logic [W-1:0] zext_sum [LANES];
  logic [W-1:0] zshl;
  logic [1:0]   scale;
  logic         use_zext;

  assign a_zext = {{HALF{1'b0}}, a[HALF-1:0]};

  // One adder per scale factor, for the full and the zero-extended operand
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign full_sum[k] = (a << k) + b;
    assign zext_sum[k] = (a_zext << k) + b;
  end

  // Shift-only form: short amounts use the zero-extended word
  always_comb begin
    if (shamt < SHW'(HALF)) zshl = a_zext << shamt;
    else                    zshl = a << shamt;
  end

  assign scale    = add_scale(op);
  assign use_zext = add_zext(op);

  always_comb begin
    if (op == OP_ZSHL)
      res = zshl;
    else if (op_group(op) == GRP_ADD)
      res = use_zext ? zext_sum[scale] : full_sum[scale];
    else
      res = '0;
  end

endmodule

// File: rtl/pkscl_cmp.sv
module pkscl_cmp #(
  parameter int W = pkscl_pkg::DW
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  import pkscl_pkg::*;

  localparam int NSX = 2;

  logic         a_lt_s;
  logic         a_lt_u;
  logic [W-1:0] sx [NSX];

  assign a_lt_s = $signed(a) < $signed(b);
  assign a_lt_u = a < b;

  // Sign extension from byte (g=0) and halfword (g=1)
  for (genvar g = 0; g < NSX; g++) begin : g_sx
    localparam int SXW = 8 << g;
    assign sx[g] = {{(W-SXW){a[SXW-1]}}, a[SXW-1:0]};
  end

  always_comb begin
    case (op)
      OP_SMIN: res = a_lt_s ? a : b;
      OP_SMAX: res = a_lt_s ? b : a;
      OP_UMIN: res = a_lt_u ? a : b;
      OP_UMAX: res = a_lt_u ? b : a;
      OP_SX8:  res = sx[0];
      OP_SX16: res = sx[1];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/pkscl_unit.sv
module pkscl_unit #(
  parameter int W       = pkscl_pkg::DW,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [4:0]           op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [$clog2(W)-1:0] shamt,
  output logic [W-1:0]         result,
  output logic                 out_valid,
  output logic [W-1:0]         out_result
);
  import pkscl_pkg::*;

  logic [W-1:0] pack_res;
  logic [W-1:0] add_res;
  logic [W-1:0] cmp_res;
  grp_e         grp;
  logic         op_known;

  pkscl_pack #(.W(W)) u_pack (
    .op  (op),
    .a   (a),
    .b   (b),
    .res (pack_res)
  );

  pkscl_scadd #(.W(W)) u_scadd (
    .op    (op),
    .a     (a),
    .b     (b),
    .shamt (shamt),
    .res   (add_res)
  );

  pkscl_cmp #(.W(W)) u_cmp (
    .op  (op),
    .a   (a),
    .b   (b),
    .res (cmp_res)
  );

  assign grp      = op_group(op);
  assign op_known = (grp != GRP_NONE);

  always_comb begin
    case (grp)
      GRP_PACK: result = pack_res;
      GRP_ADD:  result = add_res;
      GRP_CMP:  result = cmp_res;
      default:  result = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) res_q <= result;
      end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_valid_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_result == $past(result)));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign out_result = result;
  end

  // Family-level checks on the combinational result
  assert_smin_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SMIN) |->
      ($signed(result) <= $signed(a) && $signed(result) <= $signed(b)));
  assert_umax_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_UMAX) |-> (result >= a && result >= b));
  assert_byte_pack_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PACK_BYTE) |-> (result[W-1:16] == '0));
  assert_sx8_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SX8) |->
      ($countones(result[W-1:7]) == 0 || $countones(result[W-1:7]) == W-7));
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known) |-> (result == '0));

endmodule

// File: tb/pkscl_unit_test.sv
module pkscl_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] A0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] B0 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [4:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [5:0]  sh;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    '{5'd0,  A0, B0, 6'd0, 64'h7654_3210_89AB_CDEF},   // R1
    '{5'd1,  A0, B0, 6'd0, 64'hFEDC_BA98_0123_4567},   // R1
    '{5'd2,  A0, B0, 6'd0, 64'h0000_0000_0000_10EF},   // R2
    '{5'd2,  ~64'h0, ~64'h0, 6'd0, 64'h0000_0000_0000_FFFF}, // R2
    '{5'd3,  A0, B0, 6'd0, 64'h0000_0000_3210_CDEF},   // R3
    '{5'd3,  B0, A0, 6'd0, 64'hFFFF_FFFF_CDEF_3210},   // R3
    '{5'd4,  A0, B0, 6'd0, 64'h0000_0000_7654_89AB},   // R3
    '{5'd4,  B0, A0, 6'd0, 64'hFFFF_FFFF_89AB_7654},   // R3
    '{5'd5,  A0, B0, 6'd0, 64'h0123_4567_89AB_CDEE},   // R4
    '{5'd6,  A0, B0, 6'd0, 64'h0369_D036_9D03_69CC},   // R4
    '{5'd7,  A0, B0, 6'd0, 64'h07F6_E5D4_C3B2_A188},   // R4
    '{5'd7,  MINS, 64'd5, 6'd0, 64'h0000_0000_0000_0005}, // R4 wrap
    '{5'd8,  A0, B0, 6'd0, 64'hFEDC_BA98_FFFF_FFFF},   // R5
    '{5'd9,  A0, B0, 6'd0, 64'hFEDC_BA99_89AB_CDEE},   // R5
    '{5'd10, A0, B0, 6'd0, 64'hFEDC_BA9A_9D03_69CC},   // R5
    '{5'd11, A0, B0, 6'd0, 64'hFEDC_BA9C_C3B2_A188},   // R5
    '{5'd8,  ~64'h0, 64'h1, 6'd0, 64'h0000_0001_0000_0000}, // R5
    '{5'd12, A0, B0, 6'd0,  64'h0000_0000_89AB_CDEF},  // R6
    '{5'd12, A0, B0, 6'd4,  64'h0000_0008_9ABC_DEF0},  // R6
    '{5'd12, A0, B0, 6'd31, 64'h44D5_E6F7_8000_0000},  // R6
    '{5'd12, A0, B0, 6'd32, 64'h89AB_CDEF_0000_0000},  // R6
    '{5'd12, A0, B0, 6'd36, 64'h9ABC_DEF0_0000_0000},  // R6
    '{5'd12, A0, B0, 6'd63, 64'h8000_0000_0000_0000},  // R6
    '{5'd13, A0, B0, 6'd0, B0},                        // R7
    '{5'd14, A0, B0, 6'd0, A0},                        // R7
    '{5'd13, MINS, MAXS, 6'd0, MINS},                  // R7
    '{5'd14, MINS, MAXS, 6'd0, MAXS},                  // R7
    '{5'd14, MAXS, MAXS, 6'd0, MAXS},                  // R7
    '{5'd15, A0, B0, 6'd0, A0},                        // R8
    '{5'd16, A0, B0, 6'd0, B0},                        // R8
    '{5'd15, MINS, MAXS, 6'd0, MAXS},                  // R8
    '{5'd16, MINS, MAXS, 6'd0, MINS},                  // R8
    '{5'd17, A0, B0, 6'd0, 64'hFFFF_FFFF_FFFF_FFEF},   // R9
    '{5'd17, 64'h7F, B0, 6'd0, 64'h0000_0000_0000_007F}, // R9
    '{5'd17, 64'h80, B0, 6'd0, 64'hFFFF_FFFF_FFFF_FF80}, // R9
    '{5'd18, A0, B0, 6'd0, 64'hFFFF_FFFF_FFFF_CDEF},   // R9
    '{5'd18, B0, A0, 6'd0, 64'h0000_0000_0000_3210},   // R9
    '{5'd19, A0, B0, 6'd7, 64'h0},                     // R10
    '{5'd25, ~64'h0, ~64'h0, 6'd0, 64'h0},             // R10
    '{5'd31, A0, B0, 6'd40, 64'h0}                     // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [5:0]  shamt = '0;
  logic [63:0] result;
  logic        out_valid;
  logic [63:0] out_result;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkscl_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .a          (a),
    .b          (b),
    .shamt      (shamt),
    .result     (result),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  function automatic string req_of(input logic [4:0] c);
    if (c <= 1) return "R1";
    if (c == 2) return "R2";
    if (c <= 4) return "R3";
    if (c <= 7) return "R4";
    if (c <= 11) return "R5";
    if (c == 12) return "R6";
    if (c <= 14) return "R7";
    if (c <= 16) return "R8";
    if (c <= 18) return "R9";
    return "R10";
  endfunction

  // Independent reference model
  function automatic logic [63:0] model(input logic [4:0] c, input logic [63:0] x,
                                        input logic [63:0] y, input logic [5:0] s);
    logic [63:0] xz;
    logic [31:0] w;
    xz = x & 64'h0000_0000_FFFF_FFFF;
    case (c)
      5'd0:  return (y << 32) | xz;
      5'd1:  return (y & 64'hFFFF_FFFF_0000_0000) | (x >> 32);
      5'd2:  return ((y & 64'hFF) << 8) | (x & 64'hFF);
      5'd3:  return 64'($signed(y[15:0])) << 16 | (x & 64'hFFFF);
      5'd4:  begin w = {y[31:16], x[31:16]}; return 64'($signed(w)); end
      5'd5:  return x * 2 + y;
      5'd6:  return x * 4 + y;
      5'd7:  return x * 8 + y;
      5'd8:  return xz + y;
      5'd9:  return xz * 2 + y;
      5'd10: return xz * 4 + y;
      5'd11: return xz * 8 + y;
      5'd12: return xz << s;
      5'd13: return ($signed(x) > $signed(y)) ? y : x;
      5'd14: return ($signed(x) > $signed(y)) ? x : y;
      5'd15: return (x > y) ? y : x;
      5'd16: return (x > y) ? x : y;
      5'd17: return 64'($signed(x << 56) >>> 56);
      5'd18: return 64'($signed(x << 48) >>> 48);
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one operation, check the combinational and the registered result
  task automatic run_op(input logic [4:0] c, input logic [63:0] x, input logic [63:0] y,
                        input logic [5:0] s, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op = c; a = x; b = y; shamt = s;
    #1;
    check(req_of(c), "result", result, exp);
    @(posedge clk);
    #1;
    check("R11", "out_valid", {63'h0, out_valid}, 64'h1);
    check("R11", "out_result", out_result, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] held;
    // R12: reset state
    #(CLK_PERIOD * 2 + 1);
    check("R12", "out_valid in reset", {63'h0, out_valid}, 64'h0);
    check("R12", "out_result in reset", out_result, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_op(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].sh, TBL[i].exp);

    for (int i = 0; i < 600; i++) begin
      logic [4:0]  c;
      logic [63:0] x;
      logic [63:0] y;
      logic [5:0]  s;
      c = 5'(i % 19);
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      s = 6'($urandom);
      run_op(c, x, y, s, model(c, x, y, s));
    end

    // R11: idle cycle keeps the register, scrambled inputs ignored
    run_op(5'd0, A0, B0, 6'd0, 64'h7654_3210_89AB_CDEF);
    held = out_result;
    @(negedge clk);
    in_valid = 1'b0; op = 5'd7; a = ~A0; b = ~B0;
    @(posedge clk);
    #1;
    check("R11", "out_valid after idle", {63'h0, out_valid}, 64'h0);
    check("R11", "out_result held", out_result, held);
    @(posedge clk);
    #1;
    check("R11", "out_result held two cycles", out_result, held);

    // R12: reset in mid-run clears the register
    run_op(5'd16, MINS, MAXS, 6'd0, MINS);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12", "out_valid after reset", {63'h0, out_valid}, 64'h0);
    check("R12", "out_result after reset", out_result, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(5'd17, 64'h80, 64'h0, 6'd0, 64'hFFFF_FFFF_FFFF_FF80);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule